// File: doc/BRIEF.md
# UART DMA Ready Handshake Generator

This block drives the two active-low DMA request lines of a UART whose transmit and receive FIFOs hold 16 characters each. It does not contain the FIFOs. It watches their fill counts, the programmed receive trigger selection, a receive time-out pulse and the FIFO enable and DMA mode bits. From these it decides when an external DMA engine should move data.

There are two signalling styles:

- **Single-transfer style.** Each line follows the presence of data. This style is always used while the FIFOs are disabled.
- **Block style.** Each line has separate set and clear thresholds. Between them the line keeps its previous level, so that a DMA burst runs until the FIFO is drained or filled.

Each line is held in a two-state machine. The receive machine has the states `RX_IDLE` (line high) and `RX_REQ` (line low). The transmit machine has the states `TX_OPEN` (line low) and `TX_HOLD` (line high).

Receive machine transitions:

- *rx_set*: `RX_IDLE`→`RX_REQ`. Taken on data present in single style. In block style it is taken on fill ≥ trigger, or on a time-out with a non-empty FIFO.
- *rx_drain*: `RX_REQ`→`RX_IDLE`. Taken on an empty FIFO.
- *rx_flush*: any state →`RX_IDLE`.

Transmit machine transitions:

- *tx_set*: `TX_OPEN`→`TX_HOLD`. Taken on any character in single style, or on a full FIFO in block style.
- *tx_drain*: `TX_HOLD`→`TX_OPEN`. Taken on an empty FIFO.
- *tx_flush*: any state →`TX_OPEN`.

Each state register updates on the clock edge after its inputs are seen. A flush strobe also overrides its line combinationally, in the same cycle.

Top module: `uart_dma_ready`

## Requirements
- R1: While and after reset, with no other activity, `rx_ready_n` is 1 and `tx_ready_n` is 0.
- R2: When `fifo_en` is 0, both lines use single-transfer style whatever the value of `dma_block_sel`. Block style applies only when `fifo_en`=1 and `dma_block_sel`=1.
- R3: In single style, `rx_ready_n` is 0 in the cycle after `rx_fill` is sampled non-zero, and 1 in the cycle after it is sampled zero.
- R4: In block style, `rx_ready_n` goes to 0 one cycle after `rx_fill` is sampled greater than or equal to the selected trigger level. It stays 1 while the fill is below that level.
- R5: In block style, a one-cycle `rx_timeout` pulse with `rx_fill` non-zero drives `rx_ready_n` to 0 on the next cycle. A time-out with an empty FIFO has no effect.
- R6: In block style, once `rx_ready_n` is 0 it stays 0 while `rx_fill` is non-zero, even below the trigger level. It returns to 1 one cycle after `rx_fill` is sampled zero.
- R7: `rx_trig_sel` encodes the trigger level as follows: 2'b00 is 1, 2'b01 is 4, 2'b10 is 8 and 2'b11 is 14 characters.
- R8: In single style, `tx_ready_n` is 1 in the cycle after `tx_fill` is sampled non-zero, and 0 in the cycle after it is sampled zero.
- R9: In block style, `tx_ready_n` goes to 1 only one cycle after `tx_fill` is sampled at 16 (full). Any lower non-zero fill leaves it 0.
- R10: In block style, once `tx_ready_n` is 1 it stays 1 while `tx_fill` is non-zero. It returns to 0 one cycle after `tx_fill` is sampled zero.
- R11: `rx_flush` forces `rx_ready_n` to 1 and `tx_flush` forces `tx_ready_n` to 0 in the same cycle. Each strobe clears its machine, so the held level does not return after the strobe unless its set condition holds again.
- R12: Apart from the flush override, an input change reaches the outputs only at the next rising clock edge, never in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | FIFOs enabled |
| dma_block_sel | input | 1 | Selects block style when FIFOs are enabled |
| rx_fill | input | 5 | Receive FIFO or holding register occupancy, 0 to 16 |
| rx_trig_sel | input | 2 | Receive trigger level select |
| rx_timeout | input | 1 | One-cycle receive time-out pulse |
| tx_fill | input | 5 | Transmit FIFO or holding register occupancy, 0 to 16 |
| rx_flush | input | 1 | Receive FIFO reset strobe |
| tx_flush | input | 1 | Transmit FIFO reset strobe |
| rx_ready_n | output | 1 | Receive DMA request, active low |
| tx_ready_n | output | 1 | Transmit DMA request, active low |

## Verification
The only internal state is one bit per line. A wrong bit shows at its port one clock after the bad transition, because each output is the state decoded directly.

The hazardous errors live in block style. A lost hold bit releases a line while the FIFO is only part-way drained. A stuck hold bit keeps the line asserted after the FIFO empties. The bench therefore walks each fill count across the set threshold, back below it, and then to empty, and checks the line one cycle after each step. The flush strobes are checked twice: before the edge for the override, and after release for the cleared state.

// File: rtl/dma_rdy_pkg.sv
package dma_rdy_pkg;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_REQ  = 1'b1
    } rx_state_e;

    typedef enum logic {
        TX_OPEN = 1'b0,
        TX_HOLD = 1'b1
    } tx_state_e;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_BLOCK  = 1'b1
    } xfer_mode_e;

endpackage

// File: rtl/dma_mode_sel.sv
module dma_mode_sel
    import dma_rdy_pkg::*;
(
    input  logic       fifo_en,
    input  logic       dma_block_sel,
    output xfer_mode_e mode
);
    // Block style only exists with FIFOs on (R2).
    always_comb begin
        if (fifo_en && dma_block_sel) mode = MODE_BLOCK;
        else                          mode = MODE_SINGLE;
    end
endmodule

// File: rtl/dma_rx_trig_dec.sv
module dma_rx_trig_dec #(
    parameter int DEPTH   = 16,
    parameter int TRIG_L0 = 1,
    parameter int TRIG_L1 = 4,
    parameter int TRIG_L2 = 8,
    parameter int TRIG_L3 = 14,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic [1:0]    sel,
    output logic [CW-1:0] level
);
    localparam int NLVL = 4;
    logic [CW-1:0] lvl_tab [NLVL];

    // R7: level table built from parameters
    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        localparam int VAL = (g == 0) ? TRIG_L0 :
                             (g == 1) ? TRIG_L1 :
                             (g == 2) ? TRIG_L2 : TRIG_L3;
        assign lvl_tab[g] = CW'(VAL);
    end

    assign level = lvl_tab[sel];
endmodule

// File: rtl/dma_rx_ready_fsm.sv
module dma_rx_ready_fsm
    import dma_rdy_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  xfer_mode_e    mode,
    input  logic [CW-1:0] fill,
    input  logic [CW-1:0] level,
    input  logic          timeout,
    input  logic          flush,
    output logic          rdy_n
);
    rx_state_e state, state_nx;
    logic      has_data;
    logic      at_trig;

    assign has_data = (fill != '0);
    assign at_trig  = (fill >= level);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (flush) begin
            state_nx = RX_IDLE;                       // rx_flush
        end else if (mode == MODE_SINGLE) begin
            state_nx = has_data ? RX_REQ : RX_IDLE;   // R3
        end else begin
            unique case (state)
                RX_IDLE: if (at_trig || (timeout && has_data)) state_nx = RX_REQ; // rx_set
                RX_REQ:  if (!has_data)                        state_nx = RX_IDLE; // rx_drain
            endcase
        end
    end

    always_comb begin
        rdy_n = (state != RX_REQ) || flush;           // R11 override
    end

    assert_rx_empty_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0) |=> rdy_n);

    assert_rx_flush_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> rdy_n);

    assert_rx_block_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BLOCK && !rdy_n && has_data && !flush) |=> (!rdy_n || flush));

    assert_rx_trig_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BLOCK && at_trig && !flush) |=> (!rdy_n || flush));

    assert_rx_level_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        level != '0);
endmodule

// File: rtl/dma_tx_ready_fsm.sv
module dma_tx_ready_fsm
    import dma_rdy_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  xfer_mode_e    mode,
    input  logic [CW-1:0] fill,
    input  logic          flush,
    output logic          rdy_n
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    tx_state_e state, state_nx;
    logic      is_full;
    logic      is_empty;

    assign is_full  = (fill == FULL);
    assign is_empty = (fill == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_OPEN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (flush) begin
            state_nx = TX_OPEN;                         // tx_flush
        end else if (mode == MODE_SINGLE) begin
            state_nx = is_empty ? TX_OPEN : TX_HOLD;    // R8
        end else begin
            unique case (state)
                TX_OPEN: if (is_full)  state_nx = TX_HOLD; // tx_set
                TX_HOLD: if (is_empty) state_nx = TX_OPEN; // tx_drain
            endcase
        end
    end

    always_comb begin
        rdy_n = (state == TX_HOLD) && !flush;           // R11 override
    end

    assert_tx_empty_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        is_empty |=> !rdy_n);

    assert_tx_flush_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !rdy_n);

    assert_tx_block_partial_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BLOCK && !rdy_n && !is_full) |=> !rdy_n);

    assert_tx_block_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BLOCK && rdy_n && !is_empty && !flush) |=> (rdy_n || flush));
endmodule

// File: rtl/uart_dma_ready.sv
module uart_dma_ready
    import dma_rdy_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int TRIG_L0 = 1,
    parameter int TRIG_L1 = 4,
    parameter int TRIG_L2 = 8,
    parameter int TRIG_L3 = 14,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          dma_block_sel,
    input  logic [CW-1:0] rx_fill,
    input  logic [1:0]    rx_trig_sel,
    input  logic          rx_timeout,
    input  logic [CW-1:0] tx_fill,
    input  logic          rx_flush,
    input  logic          tx_flush,
    output logic          rx_ready_n,
    output logic          tx_ready_n
);
    xfer_mode_e    mode;
    logic [CW-1:0] trig_level;

    dma_mode_sel u_mode (
        .fifo_en       (fifo_en),
        .dma_block_sel (dma_block_sel),
        .mode          (mode)
    );

    dma_rx_trig_dec #(
        .DEPTH (DEPTH), .TRIG_L0 (TRIG_L0), .TRIG_L1 (TRIG_L1),
        .TRIG_L2 (TRIG_L2), .TRIG_L3 (TRIG_L3)
    ) u_trig (
        .sel   (rx_trig_sel),
        .level (trig_level)
    );

    dma_rx_ready_fsm #(.DEPTH (DEPTH)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .fill    (rx_fill),
        .level   (trig_level),
        .timeout (rx_timeout),
        .flush   (rx_flush),
        .rdy_n   (rx_ready_n)
    );

    dma_tx_ready_fsm #(.DEPTH (DEPTH)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .fill  (tx_fill),
        .flush (tx_flush),
        .rdy_n (tx_ready_n)
    );

    assert_single_rx_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && rx_fill != '0 && !rx_flush) |=> (!rx_ready_n || rx_flush));

    assert_single_tx_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && tx_fill != '0 && !tx_flush) |=> (tx_ready_n || tx_flush));
endmodule

// File: tb/sim_uart_dma_ready.sv
module sim_uart_dma_ready;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0, dma_block_sel = 1'b0;
    logic [4:0] rx_fill = '0, tx_fill = '0;
    logic [1:0] rx_trig_sel = 2'b00;
    logic       rx_timeout = 1'b0, rx_flush = 1'b0, tx_flush = 1'b0;
    logic       rx_ready_n, tx_ready_n;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic  erx;
        logic  etx;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_dma_ready u0 (
        .clk (clk), .rst_n (rst_n), .fifo_en (fifo_en), .dma_block_sel (dma_block_sel),
        .rx_fill (rx_fill), .rx_trig_sel (rx_trig_sel), .rx_timeout (rx_timeout),
        .tx_fill (tx_fill), .rx_flush (rx_flush), .tx_flush (tx_flush),
        .rx_ready_n (rx_ready_n), .tx_ready_n (tx_ready_n)
    );

    task automatic chk(input logic act, input logic exp, input string what, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // driver: inputs are already set; queue expectation for after the next edge
    task automatic expect_next(input logic erx, input logic etx, input string tag);
        exp_t it;
        it.erx = erx; it.etx = etx; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    // monitor: sample a quarter period after each rising edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            chk(rx_ready_n, it.erx, "rx_ready_n", it.tag);
            chk(tx_ready_n, it.etx, "tx_ready_n", it.tag);
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD*2 + 1);
        chk(rx_ready_n, 1'b1, "rx in reset", "R1");
        chk(tx_ready_n, 1'b0, "tx in reset", "R1");
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(rx_ready_n, 1'b1, "rx after reset", "R1");
        chk(tx_ready_n, 1'b0, "tx after reset", "R1");

        // FIFOs off, block bit set: single style forced (R2)
        dma_block_sel = 1'b1; rx_trig_sel = 2'b11;
        rx_fill = 5'd1;
        #1 chk(rx_ready_n, 1'b1, "no same-cycle change", "R12");
        expect_next(1'b0, 1'b0, "R2");
        rx_fill = 5'd0;  expect_next(1'b1, 1'b0, "R3");
        tx_fill = 5'd1;  expect_next(1'b1, 1'b1, "R2");
        tx_fill = 5'd0;  expect_next(1'b1, 1'b0, "R8");

        // FIFOs on, single style
        fifo_en = 1'b1; dma_block_sel = 1'b0;
        rx_fill = 5'd3;  expect_next(1'b0, 1'b0, "R3");
        tx_fill = 5'd5;  expect_next(1'b0, 1'b1, "R8");
        rx_fill = 5'd0; tx_fill = 5'd0; expect_next(1'b1, 1'b0, "R3");

        // block style, receive thresholds
        dma_block_sel = 1'b1; rx_trig_sel = 2'b01;
        rx_fill = 5'd3;  expect_next(1'b1, 1'b0, "R4");
        rx_fill = 5'd4;  expect_next(1'b0, 1'b0, "R4");
        rx_fill = 5'd2;  expect_next(1'b0, 1'b0, "R6");
        rx_fill = 5'd0;  expect_next(1'b1, 1'b0, "R6");
        rx_trig_sel = 2'b11;
        rx_fill = 5'd13; expect_next(1'b1, 1'b0, "R7");
        rx_fill = 5'd14; expect_next(1'b0, 1'b0, "R7");
        rx_fill = 5'd0;  expect_next(1'b1, 1'b0, "R7");
        rx_trig_sel = 2'b10;
        rx_fill = 5'd7;  expect_next(1'b1, 1'b0, "R7");
        rx_fill = 5'd8;  expect_next(1'b0, 1'b0, "R7");
        rx_fill = 5'd0;  expect_next(1'b1, 1'b0, "R7");
        rx_trig_sel = 2'b00;
        rx_fill = 5'd1;  expect_next(1'b0, 1'b0, "R7");
        rx_fill = 5'd0;  expect_next(1'b1, 1'b0, "R7");

        // time-out
        rx_trig_sel = 2'b11;
        rx_fill = 5'd2;  expect_next(1'b1, 1'b0, "R5");
        rx_timeout = 1'b1; expect_next(1'b0, 1'b0, "R5");
        rx_timeout = 1'b0; expect_next(1'b0, 1'b0, "R6");
        rx_fill = 5'd0;  expect_next(1'b1, 1'b0, "R6");
        rx_timeout = 1'b1; expect_next(1'b1, 1'b0, "R5");
        rx_timeout = 1'b0; expect_next(1'b1, 1'b0, "R5");

        // block style, transmit thresholds
        tx_fill = 5'd1;  expect_next(1'b1, 1'b0, "R9");
        tx_fill = 5'd15; expect_next(1'b1, 1'b0, "R9");
        tx_fill = 5'd16; expect_next(1'b1, 1'b1, "R9");
        tx_fill = 5'd10; expect_next(1'b1, 1'b1, "R10");
        tx_fill = 5'd0;  expect_next(1'b1, 1'b0, "R10");

        // flush strobes
        rx_trig_sel = 2'b01;
        rx_fill = 5'd4;  expect_next(1'b0, 1'b0, "R11");
        rx_fill = 5'd2;  expect_next(1'b0, 1'b0, "R11");
        rx_flush = 1'b1;
        #1 chk(rx_ready_n, 1'b1, "rx override same cycle", "R11");
        expect_next(1'b1, 1'b0, "R11");
        rx_flush = 1'b0; expect_next(1'b1, 1'b0, "R11");
        rx_fill = 5'd0;
        tx_fill = 5'd16; expect_next(1'b1, 1'b1, "R11");
        tx_fill = 5'd8;  expect_next(1'b1, 1'b1, "R11");
        tx_flush = 1'b1;
        #1 chk(tx_ready_n, 1'b0, "tx override same cycle", "R11");
        expect_next(1'b1, 1'b0, "R11");
        tx_flush = 1'b0; expect_next(1'b1, 1'b0, "R11");

        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule